// File: doc/BRIEF.md
# Two-Bit Coded Morse Message Keyer

This block holds a short identification message as a list of two-bit Morse symbols and, when triggered, plays it out as an on/off keying waveform. Each stored symbol is a dot, a dash, a gap or an end marker. The keyer inserts the one-unit silence after every dot and dash itself, so only the longer letter and word gaps need to be stored. Element timing comes from an external code-speed tick, one pulse per Morse unit.

Symbols are fetched by a column counter (ten positions) and a row counter (four positions). The column counter advances once per finished symbol, and when it wraps it advances the row. Playback stops on the end code, or after the last location if no end code is present. A message is usually written with a few leading gap symbols, so the transmitter has time to key up. It uses one gap between letters, three gaps between words, and an end code last.

Top module: `morse_keyer`

## Requirements
- R1: After reset, busy_o, key_o and gate_o are low, and every memory location holds the end code, so a start with no message written returns to idle without keying.
- R2: Symbol codes on wr_code_i are: 2'b00 dot, 2'b01 dash, 2'b10 gap, 2'b11 end. Location index L = row*10 + column is written through wr_addr_i = L.
- R3: A dot gives key_o high for one unit, then low for one unit.
- R4: A dash gives key_o high for three units, then low for one unit.
- R5: A gap keeps key_o and gate_o low for two units.
- R6: A start pulse while idle raises busy_o on the next clock edge, and playback begins at location 0 with its first unit.
- R7: Locations are played in index order. After column 9 of a row, playback continues at column 0 of the next row.
- R8: When the current location holds the end code, busy_o falls on the next clock edge and key_o goes low. Ticks while idle change nothing.
- R9: If none of the 40 locations holds the end code, playback stops after the last unit of location 39.
- R10: A start pulse while busy is ignored and does not disturb the playback in progress.
- R11: gate_o is high for the whole of a dot or dash symbol, including its trailing silent unit. key_o and gate_o are registered outputs that follow the playback state one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start playback (effective only while idle) |
| unit_tick_i | input | 1 | One-cycle pulse marking the end of a Morse unit |
| wr_en_i | input | 1 | Memory write strobe |
| wr_addr_i | input | 6 | Location index written |
| wr_code_i | input | 2 | Symbol code written |
| key_o | output | 1 | Tone on |
| gate_o | output | 1 | High during dot and dash symbols |
| busy_o | output | 1 | Playback in progress |

## Verification
The bench builds the keyer with its default ten columns by four rows. With that size, a short message that runs from column 9 into the second row checks the row carry. An all-dot message reaches the unterminated stop after location 39 in 80 units. The unit tick is pulsed every few clocks, so the registered key and gate outputs can be compared against a unit-by-unit expected waveform. That waveform is derived from a copy of the written symbols.

// File: rtl/morse_keyer.sv
module morse_keyer #(
  parameter int COLS = 10,
  parameter int ROWS = 4,
  localparam int DEPTH = COLS * ROWS,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(COLS),
  localparam int RW = $clog2(ROWS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          unit_tick_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [1:0]    wr_code_i,
  output logic          key_o,
  output logic          gate_o,
  output logic          busy_o
);
  localparam logic [1:0] SYM_DOT  = 2'b00;
  localparam logic [1:0] SYM_DASH = 2'b01;
  localparam logic [1:0] SYM_GAP  = 2'b10;
  localparam logic [1:0] SYM_END  = 2'b11;

  logic [1:0]    sym_mem [DEPTH];
  logic [CW-1:0] col_q;
  logic [RW-1:0] row_q;
  logic [1:0]    ph_q;
  logic          run_q, key_q, gate_q;

  logic [AW-1:0] loc;
  logic [1:0]    cur;
  logic [1:0]    last_ph;
  logic          tone_on, is_mark;

  assign loc     = AW'(row_q) * AW'(COLS) + AW'(col_q);
  assign cur     = sym_mem[loc];
  assign last_ph = (cur == SYM_DASH) ? 2'd3 : 2'd1;
  assign is_mark = (cur == SYM_DOT) || (cur == SYM_DASH);
  assign tone_on = ((cur == SYM_DOT) && (ph_q == 2'd0)) ||
                   ((cur == SYM_DASH) && (ph_q != 2'd3));

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      col_q  <= '0;
      row_q  <= '0;
      ph_q   <= '0;
      key_q  <= 1'b0;
      gate_q <= 1'b0;
      for (int i = 0; i < DEPTH; i++) sym_mem[i] <= SYM_END;
    end else begin
      if (wr_en_i && (wr_addr_i < AW'(DEPTH))) sym_mem[wr_addr_i] <= wr_code_i;
      key_q  <= run_q && tone_on;
      gate_q <= run_q && is_mark;
      if (!run_q) begin
        if (start_i) begin
          run_q <= 1'b1;
          col_q <= '0;
          row_q <= '0;
          ph_q  <= '0;
        end
      end else if (cur == SYM_END) begin
        run_q <= 1'b0;
      end else if (unit_tick_i) begin
        if (ph_q == last_ph) begin
          ph_q <= '0;
          if (col_q == CW'(COLS - 1)) begin
            col_q <= '0;
            if (row_q == RW'(ROWS - 1)) run_q <= 1'b0;
            else row_q <= row_q + 1'b1;
          end else begin
            col_q <= col_q + 1'b1;
          end
        end else begin
          ph_q <= ph_q + 1'b1;
        end
      end
    end
  end

  assign key_o  = key_q;
  assign gate_o = gate_q;
  assign busy_o = run_q;
endmodule

// File: rtl/morse_keyer_chk.sv
module morse_keyer_chk #(
  parameter int COLS = 10,
  parameter int ROWS = 4,
  localparam int CW = $clog2(COLS),
  localparam int RW = $clog2(ROWS)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          unit_tick_i,
  input logic          busy_o,
  input logic          key_o,
  input logic          gate_o,
  input logic [CW-1:0] col_q,
  input logic [RW-1:0] row_q,
  input logic [1:0]    ph_q,
  input logic [1:0]    cur
);
  assert_idle_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (busy_o && col_q == '0 && row_q == '0 && ph_q == '0));

  assert_busy_start_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !unit_tick_i) |=> ($stable(col_q) && $stable(row_q) && $stable(ph_q)));

  assert_end_stops_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cur == 2'b11) |=> !busy_o);

  assert_idle_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> (!busy_o && $stable(col_q) && $stable(row_q)));

  assert_key_needs_run_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_o |-> $past(busy_o));

  assert_gap_silent_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cur == 2'b10) |=> (!key_o && !gate_o));

  assert_scan_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(col_q) < COLS) && (32'(row_q) < ROWS));
endmodule

bind morse_keyer morse_keyer_chk #(.COLS(COLS), .ROWS(ROWS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .unit_tick_i(unit_tick_i),
  .busy_o(busy_o), .key_o(key_o), .gate_o(gate_o),
  .col_q(col_q), .row_q(row_q), .ph_q(ph_q), .cur(cur)
);

// File: tb/morse_keyer_bench.sv
module morse_keyer_bench;
  localparam int DEPTH = 40;
  localparam int AW = 6;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [1:0] wr_code = '0;
  logic key, gate, busy;

  always #2 clk = ~clk;

  morse_keyer u_morse_keyer (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .unit_tick_i(tick),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_code_i(wr_code),
    .key_o(key), .gate_o(gate), .busy_o(busy)
  );

  int n_chk = 0, n_fail = 0;
  logic [1:0] model [DEPTH];
  int ek [512];
  int eg [512];
  int n_units;

  task automatic check(input string req, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic put(input int a, input logic [1:0] c);
    model[a] = c;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_code = c;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic add_unit(input int k, input int g);
    ek[n_units] = k; eg[n_units] = g; n_units++;
  endtask

  task automatic build();
    n_units = 0;
    for (int i = 0; i < DEPTH; i++) begin
      if (model[i] == 2'b11) break;
      case (model[i])
        2'b00: begin add_unit(1, 1); add_unit(0, 1); end
        2'b01: begin add_unit(1, 1); add_unit(1, 1); add_unit(1, 1); add_unit(0, 1); end
        default: begin add_unit(0, 0); add_unit(0, 0); end
      endcase
    end
  endtask

  task automatic play(input string req, input int restart_at);
    build();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < n_units; i++) begin
      repeat (2) @(negedge clk);
      check(req, $sformatf("key unit %0d", i), int'(key), ek[i]);
      check(req, $sformatf("gate unit %0d", i), int'(gate), eg[i]);
      check(req, $sformatf("busy unit %0d", i), int'(busy), 1);
      if (i == restart_at) begin
        start = 1'b1; @(negedge clk); start = 1'b0;
      end
      tick = 1'b1; @(negedge clk); tick = 1'b0;
    end
    repeat (3) @(negedge clk);
    check(req, "busy after message", int'(busy), 0);
    check(req, "key after message", int'(key), 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1", "busy in reset", int'(busy), 0);
    check("R1", "key in reset", int'(key), 0);
    check("R1", "gate in reset", int'(gate), 0);
    rst_n = 1'b1;
    for (int i = 0; i < DEPTH; i++) model[i] = 2'b11;
    play("R1", -1);
  endtask

  task automatic t_letters();
    put(0, 2'b10); put(1, 2'b10); put(2, 2'b00); put(3, 2'b01); put(4, 2'b10);
    put(5, 2'b01); put(6, 2'b00); put(7, 2'b00); put(8, 2'b00); put(9, 2'b11);
    play("R2/R3/R4/R5/R6/R11", -1);
  endtask

  task automatic t_rows();
    put(9, 2'b00); put(10, 2'b01); put(11, 2'b10); put(12, 2'b00); put(13, 2'b11);
    play("R7", -1);
  endtask

  task automatic t_restart();
    play("R10", 5);
  endtask

  task automatic t_after_end();
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); tick = 1'b1; @(negedge clk); tick = 1'b0;
      @(negedge clk);
      check("R8", "busy idle tick", int'(busy), 0);
      check("R8", "key idle tick", int'(key), 0);
    end
  endtask

  task automatic t_full();
    for (int i = 0; i < DEPTH; i++) put(i, 2'b00);
    play("R9", -1);
  endtask

  initial begin
    t_reset();
    t_letters();
    t_rows();
    t_restart();
    t_after_end();
    t_full();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(4 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule